// File: doc/BRIEF.md
# Resynchronized Selectable-Source Clock Divider

This block is one programmable divider channel that lives entirely in a fast master-clock domain. Eight candidate source clocks enter the channel, and each one is brought into the master domain by its own synchronizer chain. A rising edge seen on the synchronized copy becomes a one-cycle tick. A 3-bit select picks one tick stream. A state machine counts the ticks against a 16-bit ratio and produces an output that is high for the larger half of the ratio and low for the smaller half. The output register and all counting registers use the master clock as their only clock. The sources act only as enables.

A new select or ratio does not take effect at once. The channel takes it up at the next terminal count, which always falls at the end of a low phase, so a running high phase is never shortened. Changing the source sends the channel through an alignment state that keeps the output low until the first edge of the new source arrives. Removing the enable lets the current high phase finish and then parks the output low. Each wrap of the counter emits a one-master-cycle terminal-count strobe. That strobe can serve as a source input of a second channel, and the two channels together then divide by the product of their ratios.

The state machine has four states:
- `CD_OFF` is idle, with the output low and the counter cleared.
- `CD_ALIGN` waits, with the output low, for the first tick of the selected source.
- `CD_HIGH` is the output-high phase.
- `CD_LOW` is the output-low phase.

Its transitions are:
- OFF→ALIGN when enabled. The requested configuration is latched.
- ALIGN→HIGH on a tick.
- ALIGN→OFF when disabled.
- HIGH→LOW on the last high tick while enabled.
- HIGH→OFF on the last high tick while disabled.
- LOW→HIGH on the terminal count when the source is unchanged.
- LOW→ALIGN on the terminal count when the source changes.
- LOW→OFF when disabled.

Top module: `clkdiv_channel`

## Requirements
- R1: While reset is asserted and after its release with enable low, `div_out` and `tc_pulse` are 0.
- R2: With enable high, the output period equals N periods of the selected source, where N is `div_val` (selected by `src_sel`, value i picks `src_clk[i]`).
- R3: A `div_val` of 0 or 1 divides by 2.
- R4: For ratio N, the output is high for ceil(N/2) source periods and low for floor(N/2) source periods.
- R5: `div_out` changes only in the master cycle that follows a detected rising edge of the selected source.
- R6: A change of `div_val` during a period takes effect only after the next terminal count; the running high and low phases keep the old lengths.
- R7: After a change of source, and when starting from idle, the output stays low until the first edge of the new source, and the next high phase lasts a full ceil(N/2) periods of that source.
- R8: When enable is deasserted during a high phase, that phase completes at full length, after which the output stays low and no strobe is issued while enable is low.
- R9: `tc_pulse` is high for exactly one master cycle per period, only at the end of a low phase, and in the same cycle as the output rises when the source is unchanged.
- R10: Feeding `tc_pulse` of one channel into a source input of a second channel makes the second channel divide by the product of both ratios.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_m | input | 1 | Master clock; the only clock of all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_clk | input | NUM_SRC (8) | Candidate source clocks, asynchronous to clk_m |
| src_sel | input | SEL_W (3) | Requested source index |
| div_val | input | DIV_W (16) | Requested divide ratio; values below 2 act as 2 |
| enable | input | 1 | Channel run request |
| div_out | output | 1 | Divided clock, registered on clk_m |
| tc_pulse | output | 1 | One-cycle terminal-count strobe for cascading |

## Verification
On every cycle, the bound checker verifies four things: output edges follow a selected-source tick (R5), the strobe lasts one cycle and appears only at the end of a low phase (R9), and a disabled channel whose output is low stays low with no strobe (R8). The exact high and low lengths, the clamping of small ratios, the deferred take-up of a new ratio or source, the full-length first high phase after a switch, and the product division of a cascaded pair all depend on counts across many source periods. Only the bench scenarios can show these, by measuring them against sources with known periods.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        CD_OFF   = 2'd0,
        CD_ALIGN = 2'd1,
        CD_HIGH  = 2'd2,
        CD_LOW   = 2'd3
    } cd_state_t;

endpackage

// File: rtl/clkdiv_edge_sync.sv
module clkdiv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-1:0], async_in};
        end
    end

    // Last synchronizer stage high while the history stage is still low.
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

endmodule

// File: rtl/clkdiv_ratio.sv
module clkdiv_ratio #(
    parameter int DIV_W = 16
) (
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] hi_lim,
    output logic [DIV_W-1:0] lo_lim
);

    localparam logic [DIV_W-1:0] MIN_RATIO = DIV_W'(2);

    logic [DIV_W-1:0] ratio;

    always_comb begin
        ratio  = (div_val < MIN_RATIO) ? MIN_RATIO : div_val;
        // High phase lasts ceil(N/2) ticks, low phase lasts floor(N/2) ticks.
        // Each limit is stored as the phase length minus one.
        hi_lim = (ratio - DIV_W'(1)) >> 1;
        lo_lim = (ratio - DIV_W'(2)) >> 1;
    end

endmodule

// File: rtl/clkdiv_fsm.sv
module clkdiv_fsm
    import clkdiv_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int DIV_W   = 16,
    parameter int SEL_W   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [SEL_W-1:0]   req_sel,
    input  logic [DIV_W-1:0]   req_hi_lim,
    input  logic [DIV_W-1:0]   req_lo_lim,
    input  logic [NUM_SRC-1:0] rise_vec,
    output logic               div_out,
    output logic               tc_pulse,
    output logic               tick_o,
    output cd_state_t          state_o
);

    cd_state_t        state_q, state_n;
    logic [DIV_W-1:0] cnt_q, cnt_n;
    logic [SEL_W-1:0] act_sel_q;
    logic [DIV_W-1:0] act_hi_q, act_lo_q;
    logic             load_cfg;
    logic             tc_n;
    logic             tick;

    assign tick    = rise_vec[act_sel_q];
    assign tick_o  = tick;
    assign state_o = state_q;

    // Next-state logic.
    always_comb begin
        state_n  = state_q;
        cnt_n    = cnt_q;
        load_cfg = 1'b0;
        tc_n     = 1'b0;
        unique case (state_q)
            CD_OFF: begin
                cnt_n = '0;
                if (enable) begin
                    load_cfg = 1'b1;
                    state_n  = CD_ALIGN;
                end
            end
            CD_ALIGN: begin
                if (!enable) begin
                    state_n = CD_OFF;
                end else if (tick) begin
                    cnt_n   = '0;
                    state_n = CD_HIGH;
                end
            end
            CD_HIGH: begin
                if (tick) begin
                    if (cnt_q == act_hi_q) begin
                        cnt_n   = '0;
                        state_n = enable ? CD_LOW : CD_OFF;
                    end else begin
                        cnt_n = cnt_q + DIV_W'(1);
                    end
                end
            end
            CD_LOW: begin
                if (!enable) begin
                    cnt_n   = '0;
                    state_n = CD_OFF;
                end else if (tick) begin
                    if (cnt_q == act_lo_q) begin
                        tc_n     = 1'b1;
                        cnt_n    = '0;
                        load_cfg = 1'b1;
                        state_n  = (req_sel != act_sel_q) ? CD_ALIGN : CD_HIGH;
                    end else begin
                        cnt_n = cnt_q + DIV_W'(1);
                    end
                end
            end
        endcase
    end

    // State, counter and active configuration registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= CD_OFF;
            cnt_q     <= '0;
            act_sel_q <= '0;
            act_hi_q  <= '0;
            act_lo_q  <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
            if (load_cfg) begin
                act_sel_q <= req_sel;
                act_hi_q  <= req_hi_lim;
                act_lo_q  <= req_lo_lim;
            end
        end
    end

    // Registered outputs.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_out  <= 1'b0;
            tc_pulse <= 1'b0;
        end else begin
            div_out  <= (state_n == CD_HIGH);
            tc_pulse <= tc_n;
        end
    end

endmodule

// File: rtl/clkdiv_channel.sv
module clkdiv_channel
    import clkdiv_pkg::*;
#(
    parameter  int NUM_SRC     = 8,
    parameter  int DIV_W       = 16,
    parameter  int SYNC_STAGES = 2,
    localparam int SEL_W       = $clog2(NUM_SRC)
) (
    input  logic               clk_m,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_clk,
    input  logic [SEL_W-1:0]   src_sel,
    input  logic [DIV_W-1:0]   div_val,
    input  logic               enable,
    output logic               div_out,
    output logic               tc_pulse
);

    logic [NUM_SRC-1:0] rise_vec;
    logic [DIV_W-1:0]   hi_lim, lo_lim;
    logic               sel_tick;
    cd_state_t          core_state;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_sync
        clkdiv_edge_sync #(
            .STAGES(SYNC_STAGES)
        ) u_sync (
            .clk     (clk_m),
            .rst_n   (rst_n),
            .async_in(src_clk[g]),
            .rise    (rise_vec[g])
        );
    end

    clkdiv_ratio #(
        .DIV_W(DIV_W)
    ) u_ratio (
        .div_val(div_val),
        .hi_lim (hi_lim),
        .lo_lim (lo_lim)
    );

    clkdiv_fsm #(
        .NUM_SRC(NUM_SRC),
        .DIV_W  (DIV_W),
        .SEL_W  (SEL_W)
    ) u_fsm (
        .clk       (clk_m),
        .rst_n     (rst_n),
        .enable    (enable),
        .req_sel   (src_sel),
        .req_hi_lim(hi_lim),
        .req_lo_lim(lo_lim),
        .rise_vec  (rise_vec),
        .div_out   (div_out),
        .tc_pulse  (tc_pulse),
        .tick_o    (sel_tick),
        .state_o   (core_state)
    );

endmodule

// File: rtl/clkdiv_channel_chk.sv
module clkdiv_channel_chk
    import clkdiv_pkg::*;
(
    input logic      clk_m,
    input logic      rst_n,
    input logic      enable,
    input logic      div_out,
    input logic      tc_pulse,
    input logic      sel_tick,
    input cd_state_t core_state
);

    assert_edge_on_tick_R5: assert property (@(posedge clk_m) disable iff (!rst_n)
        (div_out != $past(div_out)) |-> $past(sel_tick));

    assert_tc_one_cycle_R9: assert property (@(posedge clk_m) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);

    assert_tc_after_low_R9: assert property (@(posedge clk_m) disable iff (!rst_n)
        tc_pulse |-> ($past(sel_tick) && $past(core_state == CD_LOW)));

    assert_disabled_quiet_R8: assert property (@(posedge clk_m) disable iff (!rst_n)
        (!enable && !div_out) |=> (!div_out && !tc_pulse));

endmodule

bind clkdiv_channel clkdiv_channel_chk u_chk (
    .clk_m     (clk_m),
    .rst_n     (rst_n),
    .enable    (enable),
    .div_out   (div_out),
    .tc_pulse  (tc_pulse),
    .sel_tick  (sel_tick),
    .core_state(core_state)
);

// File: tb/clkdiv_channel_test.sv
module clkdiv_channel_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic [2:0]  sel = '0;
    logic [15:0] div = 16'd2;
    logic        en = 1'b0;
    logic        dout, tc;
    logic        en_hi = 1'b0;
    logic        dout_hi, tc_hi;
    logic [7:0]  src_hi;
    int          hc [8] = '{default: 0};
    int          n_checks = 0;
    int          n_errs = 0;

    always #2 clk = ~clk;

    // Source i toggles every i+1 master cycles: period 2*(i+1) cycles.
    always @(negedge clk) begin
        for (int i = 0; i < 8; i++) begin
            if (hc[i] == i) begin
                hc[i]  <= 0;
                src[i] <= ~src[i];
            end else begin
                hc[i] <= hc[i] + 1;
            end
        end
    end

    clkdiv_channel uut (
        .clk_m(clk), .rst_n(rst_n), .src_clk(src), .src_sel(sel),
        .div_val(div), .enable(en), .div_out(dout), .tc_pulse(tc)
    );

    assign src_hi = {7'b0, tc};

    clkdiv_channel uut_hi (
        .clk_m(clk), .rst_n(rst_n), .src_clk(src_hi), .src_sel(3'd0),
        .div_val(16'd3), .enable(en_hi), .div_out(dout_hi), .tc_pulse(tc_hi)
    );

    typedef struct packed {
        logic [2:0]  vsel;
        logic [15:0] vdiv;
        logic [15:0] vhi;
        logic [15:0] vlo;
        logic [15:0] vgap;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{3'd0, 16'd2, 16'd2,  16'd2,  16'd4},
        '{3'd1, 16'd3, 16'd8,  16'd4,  16'd12},
        '{3'd2, 16'd0, 16'd6,  16'd6,  16'd12},
        '{3'd0, 16'd1, 16'd2,  16'd2,  16'd4},
        '{3'd3, 16'd5, 16'd24, 16'd16, 16'd40},
        '{3'd7, 16'd4, 16'd32, 16'd32, 16'd64},
        '{3'd4, 16'd7, 16'd40, 16'd30, 16'd70},
        '{3'd5, 16'd6, 16'd36, 16'd36, 16'd72},
        '{3'd6, 16'd9, 16'd70, 16'd56, 16'd126}
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wait_tc();
        @(negedge clk);
        while (!tc) @(negedge clk);
    endtask

    task automatic wait_level(input logic lvl);
        while (dout != lvl) @(negedge clk);
    endtask

    task automatic count_level(input logic lvl, output int n);
        n = 0;
        while (dout == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic tc_gap(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!tc);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errs++;
        $display("FAIL R2 watchdog actual=timeout expected=completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        int hi, lo, hi2, gap, bad;

        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1", "div_out in reset", int'(dout), 0);
        check("R1", "tc_pulse in reset", int'(tc), 0);
        rst_n = 1'b1;
        bad = 0;
        repeat (60) begin
            @(negedge clk);
            if (dout || tc) bad++;
        end
        check("R1", "activity while disabled", bad, 0);

        // Vector table: R2 period, R3 clamp, R4 duty, R9 strobe
        en = 1'b1;
        for (int v = 0; v < 9; v++) begin
            sel = VECS[v].vsel;
            div = VECS[v].vdiv;
            wait_tc();
            wait_tc();
            check("R9", "div_out rises with strobe", int'(dout), 1);
            @(negedge clk);
            check("R9", "strobe width", int'(tc), 0);
            wait_level(1'b0);
            wait_level(1'b1);
            count_level(1'b1, hi);
            count_level(1'b0, lo);
            check(VECS[v].vdiv < 2 ? "R3" : "R4", "high length", hi, int'(VECS[v].vhi));
            check(VECS[v].vdiv < 2 ? "R3" : "R4", "low length", lo, int'(VECS[v].vlo));
            tc_gap(gap);
            check("R2", "period between strobes", gap, int'(VECS[v].vgap));
        end

        // R6: ratio change mid-period waits for terminal count
        sel = 3'd1;
        div = 16'd4;
        wait_tc();
        wait_tc();
        wait_level(1'b0);
        wait_level(1'b1);
        div = 16'd8;
        count_level(1'b1, hi);
        count_level(1'b0, lo);
        count_level(1'b1, hi2);
        check("R6", "high with old ratio", hi, 8);
        check("R6", "low with old ratio", lo, 8);
        check("R6", "high with new ratio", hi2, 16);

        // R7: source switch keeps output low until new source, full high
        div = 16'd4;
        wait_tc();
        wait_tc();
        wait_level(1'b0);
        wait_level(1'b1);
        sel = 3'd7;
        count_level(1'b1, hi);
        count_level(1'b0, lo);
        count_level(1'b1, hi2);
        check("R7", "high before switch", hi, 8);
        check("R7", "low phase not shortened", int'(lo >= 8), 1);
        check("R7", "first high on new source", hi2, 32);

        // R8: disable during high
        sel = 3'd1;
        div = 16'd6;
        wait_tc();
        wait_tc();
        wait_level(1'b0);
        wait_level(1'b1);
        en = 1'b0;
        count_level(1'b1, hi);
        check("R8", "high completes after disable", hi, 12);
        bad = 0;
        repeat (200) begin
            @(negedge clk);
            if (dout || tc) bad++;
        end
        check("R8", "quiet while disabled", bad, 0);

        // R7: start from idle gives a full first high
        sel = 3'd2;
        div = 16'd4;
        en = 1'b1;
        wait_level(1'b1);
        count_level(1'b1, hi);
        check("R7", "first high after enable", hi, 12);

        // R10: cascade, low channel divides by 3 on a 4-cycle source
        sel = 3'd1;
        div = 16'd3;
        wait_tc();
        wait_tc();
        en_hi = 1'b1;
        @(negedge clk);
        while (!tc_hi) @(negedge clk);
        check("R10", "cascaded output rises with strobe", int'(dout_hi), 1);
        hi = 0;
        while (dout_hi) begin
            hi++;
            @(negedge clk);
        end
        check("R10", "cascaded high length", hi, 24);
        while (!tc_hi) @(negedge clk);
        gap = 0;
        do begin
            @(negedge clk);
            gap++;
        end while (!tc_hi);
        check("R10", "cascaded period", gap, 36);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

endmodule